// File: doc/BRIEF.md
# Programmable Parallel I/O Port

This block gives a processor 24 general-purpose I/O lines, arranged as three 8-bit ports called A, B and C. Port C is handled as two 4-bit halves, and each half has its own direction setting. The processor reaches the block through an 8-bit data path and a 2-bit register select. Writes to the control address do one of two things. They either load the mode word, which sets directions and strobed operation, or they set or clear one bit of the port C output latch.

Port A and port B can each run in a strobed input mode. In this mode, three lines of port C take on fixed handshake roles for that port: a strobe input, a buffer-full output and an interrupt-request output. A rising strobe captures the port's pins into a holding register. A processor read of that port returns the held byte and clears both flags. Each pad is modelled as three separate signals: an input, an output and an output enable. The data bus is modelled as an input, an output and an output enable. Pads `padIn`/`padOut`/`padOe` bits 7:0 belong to port A, bits 15:8 to port B and bits 23:16 to port C.

Top module: `gpio24_port`

## Requirements
- R1: After reset every bit of `padOe` and `padOut` is 0, and a read of select 3 returns 0x9B (all groups input, no strobed mode).
- R2: Select 0, 1 and 2 address ports A, B and C, and select 3 addresses the control word. A read of a port in input mode returns its pins.
- R3: A control write with bit 7 = 1 stores bits 6:0 as the mode word and clears all three output latches and all handshake flags. Mode bits are: 5 port A strobed, 4 port A input, 3 port C upper half input, 2 port B strobed, 1 port B input, 0 port C lower half input. A group in output mode drives its latch with `padOe` = 1 from the cycle after the write.
- R4: The upper half of port C (bits 7:4) and the lower half (bits 3:0) take their direction from separate mode bits, independently of each other.
- R5: A control write with bit 7 = 0 sets the port C latch bit indexed by data bits 3:1 to the value of data bit 0. It leaves the other latch bits and the mode word unchanged.
- R6: A read of port C returns, for each bit, the driven value when that bit's output enable is 1, and the pin otherwise. A read of port A or B in output mode returns its latch.
- R7: With port A strobed, port A drives nothing. A rising edge on port C bit 4 captures the port A pins and sets port C bit 5 (buffer full). Later pin changes do not alter the value read.
- R8: With port A strobed, port C bit 3 (interrupt request) is set on that strobe edge only when port C latch bit 4 is 1. A read of port A clears bits 3 and 5 at the edge that ends the read. A strobe edge in the same cycle wins over the clear.
- R9: With port B strobed, port C bit 2 is its strobe, bit 1 its buffer-full flag and bit 0 its interrupt request. The interrupt is enabled by port C latch bit 2, and a read of port B clears both flags.
- R10: `busOe` is 1 exactly while `rdEn` is 1, and `busOut` is 0 when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| busIn | input | 8 | Data from processor |
| busOut | output | 8 | Data to processor |
| busOe | output | 1 | Data bus output enable |
| padIn | input | 24 | Pin input values, C:B:A |
| padOut | output | 24 | Pin drive values, C:B:A |
| padOe | output | 24 | Pin output enables, C:B:A |

## Verification
A corrupted mode word shows up at the pads in the very next cycle, because `padOe` follows it with no delay. A corrupted port C latch appears on `padOut` one cycle after the write that should have set it, or, for a bit that is an input, on the next read of port C. A lost or stuck handshake flag becomes visible on port C bits 5, 3, 1 or 0 one edge after a strobe or a read. A wrong capture register stays hidden until the processor reads that port, so every strobe is followed by a read whose expected byte was fixed before the pins changed.

// File: rtl/gpio24_pkg.sv
package gpio24_pkg;
  localparam int PORT_W = 8;
  localparam int SEL_W  = 2;
  localparam int IDX_W  = $clog2(PORT_W);

  localparam logic [SEL_W-1:0] SEL_A   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_B   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_C   = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CTL = 2'd3;

  // handshake roles inside port C
  localparam int C_IRQ_B = 0;
  localparam int C_BF_B  = 1;
  localparam int C_STB_B = 2;
  localparam int C_IRQ_A = 3;
  localparam int C_STB_A = 4;
  localparam int C_BF_A  = 5;

  // mode word after reset: every group input, no strobed port
  localparam logic [6:0] MODE_RESET = 7'h1B;

  typedef struct packed {
    logic aStb;
    logic aIn;
    logic cHiIn;
    logic bStb;
    logic bIn;
    logic cLoIn;
  } cfg_t;

  typedef struct packed {
    logic             wrA;
    logic             wrB;
    logic             wrC;
    logic             modeWr;
    logic             bitWr;
    logic [IDX_W-1:0] bitIdx;
    logic             bitVal;
    logic             rdA;
    logic             rdB;
  } strobe_t;
endpackage

// File: rtl/gpio24_ctrl.sv
module gpio24_ctrl
  import gpio24_pkg::*;
#(
  parameter int PW = PORT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] sel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [PW-1:0]    busIn,
  output strobe_t          strb,
  output cfg_t             cfg,
  output logic [PW-1:0]    ctlView
);
  logic [PW-2:0] modeReg;
  logic          ctlWr;

  assign ctlWr = wrEn && (sel == SEL_CTL);

  always_comb begin
    strb        = '0;
    strb.wrA    = wrEn && (sel == SEL_A);
    strb.wrB    = wrEn && (sel == SEL_B);
    strb.wrC    = wrEn && (sel == SEL_C);
    strb.modeWr = ctlWr && busIn[PW-1];
    strb.bitWr  = ctlWr && !busIn[PW-1];
    strb.bitIdx = busIn[IDX_W:1];
    strb.bitVal = busIn[0];
    strb.rdA    = rdEn && (sel == SEL_A);
    strb.rdB    = rdEn && (sel == SEL_B);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            modeReg <= (PW-1)'(MODE_RESET);
    else if (strb.modeWr) modeReg <= busIn[PW-2:0];
  end

  assign cfg.aStb  = modeReg[5];
  assign cfg.aIn   = modeReg[4];
  assign cfg.cHiIn = modeReg[3];
  assign cfg.bStb  = modeReg[2];
  assign cfg.bIn   = modeReg[1];
  assign cfg.cLoIn = modeReg[0];

  assign ctlView = {1'b1, modeReg};
endmodule

// File: rtl/gpio24_hs.sv
module gpio24_hs #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          clear,
  input  logic          stbIn,
  input  logic          inte,
  input  logic          rdHit,
  input  logic [PW-1:0] dataIn,
  output logic [PW-1:0] dataHeld,
  output logic          bufFull,
  output logic          irq
);
  logic stbPrev;
  logic stbEdge;

  assign stbEdge = enable && stbIn && !stbPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbPrev  <= 1'b0;
      dataHeld <= '0;
      bufFull  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      stbPrev <= stbIn;
      if (clear) begin
        bufFull <= 1'b0;
        irq     <= 1'b0;
      end else if (stbEdge) begin
        dataHeld <= dataIn;
        bufFull  <= 1'b1;
        if (inte) irq <= 1'b1;
      end else if (rdHit) begin
        bufFull <= 1'b0;
        irq     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio24_dp.sv
module gpio24_dp
  import gpio24_pkg::*;
#(
  parameter int PW = PORT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  cfg_t             cfg,
  input  logic [PW-1:0]    ctlView,
  input  logic [SEL_W-1:0] sel,
  input  logic             rdEn,
  input  logic [PW-1:0]    busIn,
  input  logic [3*PW-1:0]  padIn,
  output logic [3*PW-1:0]  padOut,
  output logic [3*PW-1:0]  padOe,
  output logic [PW-1:0]    busOut,
  output logic             busOe
);
  logic [PW-1:0] latA, latB, latC;
  logic [PW-1:0] aPadIn, bPadIn, cPadIn;
  logic [PW-1:0] heldA, heldB;
  logic          bfA, irqA, bfB, irqB;
  logic [PW-1:0] hsOwn, hsOe, hsVal;
  logic [PW-1:0] cOut, cOe, cRead;
  logic [PW-1:0] aRead, bRead, rdMux;

  assign aPadIn = padIn[PW-1:0];
  assign bPadIn = padIn[2*PW-1:PW];
  assign cPadIn = padIn[3*PW-1:2*PW];

  always_ff @(posedge clk) begin
    if (!rstN || strb.modeWr) begin
      latA <= '0;
      latB <= '0;
      latC <= '0;
    end else begin
      if (strb.wrA) latA <= busIn;
      if (strb.wrB) latB <= busIn;
      if (strb.wrC)       latC <= busIn;
      else if (strb.bitWr) latC[strb.bitIdx] <= strb.bitVal;
    end
  end

  gpio24_hs #(.PW(PW)) u_hsA (
    .clk(clk), .rstN(rstN), .enable(cfg.aStb), .clear(strb.modeWr),
    .stbIn(cPadIn[C_STB_A]), .inte(latC[C_STB_A]), .rdHit(strb.rdA),
    .dataIn(aPadIn), .dataHeld(heldA), .bufFull(bfA), .irq(irqA)
  );

  gpio24_hs #(.PW(PW)) u_hsB (
    .clk(clk), .rstN(rstN), .enable(cfg.bStb), .clear(strb.modeWr),
    .stbIn(cPadIn[C_STB_B]), .inte(latC[C_STB_B]), .rdHit(strb.rdB),
    .dataIn(bPadIn), .dataHeld(heldB), .bufFull(bfB), .irq(irqB)
  );

  // handshake lines take over their port C bits
  always_comb begin
    hsOwn = '0;
    hsOe  = '0;
    hsVal = '0;
    if (cfg.aStb) begin
      hsOwn[C_IRQ_A] = 1'b1; hsOe[C_IRQ_A] = 1'b1; hsVal[C_IRQ_A] = irqA;
      hsOwn[C_STB_A] = 1'b1;
      hsOwn[C_BF_A]  = 1'b1; hsOe[C_BF_A]  = 1'b1; hsVal[C_BF_A]  = bfA;
    end
    if (cfg.bStb) begin
      hsOwn[C_IRQ_B] = 1'b1; hsOe[C_IRQ_B] = 1'b1; hsVal[C_IRQ_B] = irqB;
      hsOwn[C_STB_B] = 1'b1;
      hsOwn[C_BF_B]  = 1'b1; hsOe[C_BF_B]  = 1'b1; hsVal[C_BF_B]  = bfB;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_cbit
    logic baseOe;
    if (i < PW/2) begin : g_lo
      assign baseOe = !cfg.cLoIn;
    end else begin : g_hi
      assign baseOe = !cfg.cHiIn;
    end
    assign cOe[i]   = hsOwn[i] ? hsOe[i]  : baseOe;
    assign cOut[i]  = hsOwn[i] ? hsVal[i] : latC[i];
    assign cRead[i] = cOe[i] ? cOut[i] : cPadIn[i];
  end

  assign aRead = cfg.aStb ? heldA : (cfg.aIn ? aPadIn : latA);
  assign bRead = cfg.bStb ? heldB : (cfg.bIn ? bPadIn : latB);

  assign padOut = {cOut, latB, latA};
  assign padOe  = {cOe,
                   {PW{!(cfg.bIn || cfg.bStb)}},
                   {PW{!(cfg.aIn || cfg.aStb)}}};

  always_comb begin
    unique case (sel)
      SEL_A:   rdMux = aRead;
      SEL_B:   rdMux = bRead;
      SEL_C:   rdMux = cRead;
      default: rdMux = ctlView;
    endcase
  end

  assign busOut = rdEn ? rdMux : '0;
  assign busOe  = rdEn;
endmodule

// File: rtl/gpio24_port.sv
module gpio24_port
  import gpio24_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  sel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  busIn,
  output logic [7:0]  busOut,
  output logic        busOe,
  input  logic [23:0] padIn,
  output logic [23:0] padOut,
  output logic [23:0] padOe
);
  strobe_t           strb;
  cfg_t              cfg;
  logic [PORT_W-1:0] ctlView;

  gpio24_ctrl #(.PW(PORT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .rdEn(rdEn),
    .busIn(busIn), .strb(strb), .cfg(cfg), .ctlView(ctlView)
  );

  gpio24_dp #(.PW(PORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .ctlView(ctlView),
    .sel(sel), .rdEn(rdEn), .busIn(busIn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .busOut(busOut), .busOe(busOe)
  );
endmodule

// File: rtl/gpio24_chk.sv
module gpio24_chk
  import gpio24_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        rdEn,
  input logic        wrEn,
  input logic [1:0]  sel,
  input logic [23:0] padIn,
  input logic [23:0] padOut,
  input logic [23:0] padOe,
  input cfg_t        cfg,
  input logic        modeWr
);
  logic prevA, prevB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= padIn[16 + C_STB_A];
      prevB <= padIn[16 + C_STB_B];
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == 24'h0));

  a_r3_mode_clears_latch: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> (padOut[15:0] == 16'h0));

  a_r6_group_oe_whole: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(padOe[7:0]) inside {0, 8}) && ($countones(padOe[15:8]) inside {0, 8}));

  a_r7_strobe_sets_full: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.aStb && padIn[16 + C_STB_A] && !prevA && !modeWr) |=> padOut[16 + C_BF_A]);

  a_r8_read_clears_full: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.aStb && rdEn && !wrEn && sel == SEL_A && !(padIn[16 + C_STB_A] && !prevA))
      |=> !padOut[16 + C_BF_A]);

  a_r8_irq_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.aStb && padOut[16 + C_IRQ_A]) |-> padOut[16 + C_BF_A]);

  a_r9_strobe_sets_full_b: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.bStb && padIn[16 + C_STB_B] && !prevB && !modeWr) |=> padOut[16 + C_BF_B]);
endmodule

bind gpio24_port gpio24_chk u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .sel(sel),
  .padIn(padIn), .padOut(padOut), .padOe(padOe),
  .cfg(cfg), .modeWr(strb.modeWr)
);

// File: tb/sim_gpio24_port.sv
module sim_gpio24_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  busIn = 8'h0;
  logic [7:0]  busOut;
  logic        busOe;
  logic [23:0] padIn = 24'h0;
  logic [23:0] padOut;
  logic [23:0] padOe;

  int   nChk = 0;
  int   nFail = 0;
  bit   done = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  gpio24_port u0 (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .rdEn(rdEn),
    .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; busIn = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // driver: pushes the expected byte, the monitor compares it
  task automatic rd(input logic [1:0] s, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sel = s; rdEn = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulse(input int bitPos);
    @(negedge clk);
    padIn[bitPos] = 1'b1;
    @(negedge clk);
    padIn[bitPos] = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rdEn) begin
        chk("R10 busOe during read", {31'h0, busOe}, 32'h1);
        if (expQ.size() == 0) begin
          chk("scoreboard empty on read", 32'h1, 32'h0);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(t, {24'h0, busOut}, {24'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 idle bus
    chk("R1 padOe reset", {8'h0, padOe}, 32'h0);
    chk("R1 padOut reset", {8'h0, padOut}, 32'h0);
    chk("R10 busOe idle", {31'h0, busOe}, 32'h0);
    chk("R10 busOut idle", {24'h0, busOut}, 32'h0);
    rd(2'd3, 8'h9B, "R1 control reset value");

    // R2 select map, input reads
    padIn = 24'h96C35A;
    rd(2'd0, 8'h5A, "R2 read port A pins");
    rd(2'd1, 8'hC3, "R2 read port B pins");
    rd(2'd2, 8'h96, "R2 read port C pins");

    // R3 all outputs
    wr(2'd3, 8'h80);
    chk("R3 all drive", {8'h0, padOe}, 32'h00FFFFFF);
    chk("R3 latches clear", {8'h0, padOut}, 32'h0);
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h22);
    wr(2'd2, 8'h33);
    chk("R3 latches driven", {8'h0, padOut}, 32'h00332211);
    rd(2'd0, 8'h11, "R6 output port reads latch");
    rd(2'd3, 8'h80, "R3 control readback");
    wr(2'd3, 8'h80);
    chk("R3 mode write clears latches", {8'h0, padOut}, 32'h0);

    // R4 / R6 nibble independence and mixed read
    wr(2'd3, 8'h88);
    chk("R4 upper half input", {8'h0, padOe}, 32'h000FFFFF);
    wr(2'd2, 8'hA5);
    chk("R4 C latch on pads", {8'h0, padOut}, 32'h00A50000);
    padIn[23:16] = 8'h3C;
    rd(2'd2, 8'h35, "R6 port C mixed read hi-in");
    wr(2'd3, 8'h81);
    chk("R4 lower half input", {8'h0, padOe}, 32'h00F0FFFF);
    wr(2'd2, 8'hA5);
    rd(2'd2, 8'hAC, "R6 port C mixed read lo-in");

    // R5 bit set / reset
    padIn[23:16] = 8'h00;
    wr(2'd3, 8'h80);
    wr(2'd3, 8'h0F);
    chk("R5 set bit 7", {24'h0, padOut[23:16]}, 32'h80);
    wr(2'd3, 8'h05);
    chk("R5 set bit 2", {24'h0, padOut[23:16]}, 32'h84);
    wr(2'd3, 8'h0E);
    chk("R5 clear bit 7", {24'h0, padOut[23:16]}, 32'h04);
    rd(2'd3, 8'h80, "R5 mode word unchanged");

    // R7 / R8 port A strobed
    wr(2'd3, 8'hA0);
    chk("R7 strobed A pad enables", {8'h0, padOe}, 32'h00EFFF00);
    chk("R8 flags clear after mode", {24'h0, padOut[23:16] & 8'h28}, 32'h0);
    wr(2'd3, 8'h09);
    padIn[7:0] = 8'h77;
    pulse(20);
    chk("R8 full and irq set", {24'h0, padOut[23:16] & 8'h28}, 32'h28);
    padIn[7:0] = 8'h00;
    rd(2'd0, 8'h77, "R7 held byte survives pin change");
    chk("R8 read clears flags", {24'h0, padOut[23:16] & 8'h28}, 32'h0);
    wr(2'd3, 8'h08);
    padIn[7:0] = 8'h44;
    pulse(20);
    chk("R8 irq masked", {24'h0, padOut[23:16] & 8'h28}, 32'h20);
    rd(2'd0, 8'h44, "R7 second capture");
    chk("R8 full cleared", {24'h0, padOut[23:16] & 8'h28}, 32'h0);

    // R9 port B strobed
    wr(2'd3, 8'h84);
    chk("R9 strobed B pad enables", {8'h0, padOe}, 32'h00FB00FF);
    wr(2'd3, 8'h05);
    padIn[15:8] = 8'hE1;
    pulse(18);
    chk("R9 B full and irq set", {30'h0, padOut[17:16]}, 32'h3);
    padIn[15:8] = 8'h00;
    rd(2'd1, 8'hE1, "R9 port B held byte");
    chk("R9 B flags cleared", {30'h0, padOut[17:16]}, 32'h0);

    repeat (3) @(negedge clk);
    chk("R10 busOut idle at end", {24'h0, busOut}, 32'h0);
    chk("scoreboard drained", expQ.size(), 32'h0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule